// File: doc/BRIEF.md
# Sequential Integer Divider with Divide-Error Detection

This unit divides a dividend of twice the operand width by a divisor of one operand width. It returns a quotient and a remainder, each one operand wide. The operand width is chosen per operation as one eighth, one quarter, one half or all of the datapath width `XLEN`. Each operation runs in unsigned or signed mode. The core is a restoring shift-subtract loop that produces one quotient bit per clock. Signed operands are converted to magnitudes before the loop, and the signs are applied again afterwards.

The unit raises a divide-error flag instead of a result in two cases: the divisor is zero, or the quotient cannot be represented at the selected width. Some error conditions can be decided from the operands alone. These are resolved at once without running the loop. A quotient that turns out too large in signed mode is caught after the loop. The handshake is one `start` strobe, a `busy` level and a one-cycle `done` pulse. The results stay on the outputs until the next operation completes.

Top module: `intdiv_seq`

## Requirements
- R1: With size code s (0, 1, 2, 3 selecting n = XLEN/8, XLEN/4, XLEN/2, XLEN bits), the dividend is {dividend_hi[n-1:0], dividend_lo[n-1:0]} and the divisor is divisor[n-1:0]. Bits above n on these inputs have no effect. In unsigned mode a valid result puts the quotient and remainder in bits [n-1:0] of the outputs, with all higher output bits zero.
- R2: A divisor whose low n bits are all zero sets div_err, with quotient and remainder both zero.
- R3: In unsigned mode, when the upper dividend half is greater than or equal to the divisor (so the quotient is at least 2^n), div_err is set and quotient and remainder are zero.
- R4: In signed mode both operands are two's complement at their widths. The quotient truncates toward zero, and a nonzero remainder carries the sign of the dividend. Both results are returned as n-bit two's complement, zero-extended to XLEN.
- R5: In signed mode a negative quotient may reach -2^(n-1). A positive quotient of 2^(n-1) or more sets div_err, with zero results.
- R6: done rises n+1 clock edges after the edge that accepts start. When the error is known from the operands alone (zero divisor, or upper-half magnitude at least the divisor magnitude), done rises 1 edge after acceptance.
- R7: busy is high from the accepting edge until the edge that raises done. done lasts exactly one cycle and is never high together with busy. A start presented in the cycle where done is high is accepted.
- R8: A start asserted while busy is high is ignored. The running operation keeps its operands, its timing and its result.
- R9: quotient, remainder and div_err change only at the edge that raises done, and hold their values otherwise.
- R10: While reset is asserted, busy, done, div_err, quotient and remainder are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| start | input | 1 | Begin an operation when idle |
| size | input | 2 | Operand width code: 0=XLEN/8, 1=XLEN/4, 2=XLEN/2, 3=XLEN |
| signed_mode | input | 1 | 1 selects two's complement division |
| dividend_hi | input | XLEN | Upper half of the dividend |
| dividend_lo | input | XLEN | Lower half of the dividend |
| divisor | input | XLEN | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | XLEN | Quotient, zero-extended from n bits |
| remainder | output | XLEN | Remainder, zero-extended from n bits |
| div_err | output | 1 | Divide error for the last completed operation |

## Verification
Two functions can land in the same cycle: the completion of one operation, with done high and new results appearing, and the acceptance of the next start. The bench provokes this on every operation by raising the next start in the very cycle the model expects done. A second overlap is a start arriving while busy is high. The bench provokes it by strobing new operands midway through a division. A per-cycle reference model judges both cases: the first must be accepted with no idle gap, and the second must leave the running result and its timing untouched.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } op_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

  // operand width in bits for a size code
  function automatic int unsigned op_width(op_size_e s, int unsigned xlen);
    case (s)
      SZ_B:    return xlen / 8;
      SZ_H:    return xlen / 4;
      SZ_W:    return xlen / 2;
      default: return xlen;
    endcase
  endfunction

endpackage

// File: rtl/intdiv_prep.sv
// Operand conditioning: masks to the operand width, takes magnitudes,
// aligns the low dividend half for the shift loop, flags early errors.
module intdiv_prep
  import intdiv_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int CW = $clog2(XLEN) + 1
) (
  input  op_size_e         size_i,
  input  logic             signed_i,
  input  logic [XLEN-1:0]  hi_i,
  input  logic [XLEN-1:0]  lo_i,
  input  logic [XLEN-1:0]  dvs_i,
  output logic [XLEN-1:0]  hi_mag_o,
  output logic [XLEN-1:0]  lo_al_o,
  output logic [XLEN-1:0]  dvs_mag_o,
  output logic [CW-1:0]    nbits_o,
  output logic             neg_q_o,
  output logic             neg_r_o,
  output logic             early_err_o
);

  logic [CW-1:0]     nbits, sh;
  logic [XLEN-1:0]   mask_n, dm, hi_mag, dvs_mag;
  logic [2*XLEN-1:0] mask2, dvd2, mag2;
  logic              dvd_top, dvs_top, dvd_neg, dvs_neg;

  always_comb begin
    nbits  = CW'(op_width(size_i, XLEN));
    sh     = CW'(XLEN) - nbits;
    mask_n = {XLEN{1'b1}} >> sh;
    mask2  = {(2*XLEN){1'b1}} >> {sh, 1'b0};

    case (size_i)
      SZ_B:    begin dvd_top = hi_i[XLEN/8-1]; dvs_top = dvs_i[XLEN/8-1]; end
      SZ_H:    begin dvd_top = hi_i[XLEN/4-1]; dvs_top = dvs_i[XLEN/4-1]; end
      SZ_W:    begin dvd_top = hi_i[XLEN/2-1]; dvs_top = dvs_i[XLEN/2-1]; end
      default: begin dvd_top = hi_i[XLEN-1];   dvs_top = dvs_i[XLEN-1];   end
    endcase
    dvd_neg = signed_i & dvd_top;
    dvs_neg = signed_i & dvs_top;

    dvd2 = ({{XLEN{1'b0}}, hi_i & mask_n} << nbits) | {{XLEN{1'b0}}, lo_i & mask_n};
    mag2 = dvd_neg ? (((~dvd2) + 1'b1) & mask2) : dvd2;

    dm      = dvs_i & mask_n;
    dvs_mag = dvs_neg ? (((~dm) + 1'b1) & mask_n) : dm;
    hi_mag  = XLEN'(mag2 >> nbits);

    hi_mag_o    = hi_mag;
    lo_al_o     = (mag2[XLEN-1:0] & mask_n) << sh;
    dvs_mag_o   = dvs_mag;
    nbits_o     = nbits;
    neg_q_o     = dvd_neg ^ dvs_neg;
    neg_r_o     = dvd_neg;
    early_err_o = (dm == '0) || (hi_mag >= dvs_mag);
  end

endmodule

// File: rtl/intdiv_core.sv
// Unsigned restoring shift-subtract loop, one quotient bit per step.
module intdiv_core #(
  parameter int XLEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [XLEN-1:0]  hi_mag_i,
  input  logic [XLEN-1:0]  lo_al_i,
  input  logic [XLEN-1:0]  dvs_mag_i,
  output logic [XLEN-1:0]  rem_o,
  output logic [XLEN-1:0]  quo_o
);

  logic [XLEN-1:0] part_q, part_d, shf_q, shf_d, dvs_q, dvs_d;
  logic [XLEN:0]   trial, diff;
  logic            take, en;

  always_comb begin
    trial  = {part_q, shf_q[XLEN-1]};
    diff   = trial - {1'b0, dvs_q};
    take   = (trial >= {1'b0, dvs_q});
    part_d = part_q;
    shf_d  = shf_q;
    dvs_d  = dvs_q;
    en     = load_i | step_i;
    if (load_i) begin
      part_d = hi_mag_i;
      shf_d  = lo_al_i;
      dvs_d  = dvs_mag_i;
    end else if (step_i) begin
      part_d = take ? diff[XLEN-1:0] : trial[XLEN-1:0];
      shf_d  = {shf_q[XLEN-2:0], take};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= '0;
      shf_q  <= '0;
      dvs_q  <= '0;
    end else if (en) begin
      part_q <= part_d;
      shf_q  <= shf_d;
      dvs_q  <= dvs_d;
    end
  end

  assign rem_o = part_q;
  assign quo_o = shf_q;

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (part_q < dvs_q)); // R1

endmodule

// File: rtl/intdiv_post.sv
// Result conditioning: signed range check, sign restore, width masking.
module intdiv_post
  import intdiv_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int CW = $clog2(XLEN) + 1
) (
  input  op_size_e         size_i,
  input  logic             signed_i,
  input  logic             neg_q_i,
  input  logic             neg_r_i,
  input  logic             early_i,
  input  logic [XLEN-1:0]  quo_i,
  input  logic [XLEN-1:0]  rem_i,
  output logic [XLEN-1:0]  quo_o,
  output logic [XLEN-1:0]  rem_o,
  output logic             err_o
);

  logic [CW-1:0]   nb, sh;
  logic [XLEN-1:0] mask, half, qm, rm;
  logic            ovf, err;

  always_comb begin
    nb   = CW'(op_width(size_i, XLEN));
    sh   = CW'(XLEN) - nb;
    mask = {XLEN{1'b1}} >> sh;
    half = {{(XLEN-1){1'b0}}, 1'b1} << (nb - 1'b1);
    qm   = quo_i & mask;
    rm   = rem_i & mask;
    ovf  = signed_i && (neg_q_i ? (qm > half) : (qm >= half));
    err  = early_i || ovf;
    err_o = err;
    if (err) begin
      quo_o = '0;
      rem_o = '0;
    end else begin
      quo_o = neg_q_i ? (((~qm) + 1'b1) & mask) : qm;
      rem_o = neg_r_i ? (((~rm) + 1'b1) & mask) : rm;
    end
  end

endmodule

// File: rtl/intdiv_seq.sv
// Sequential divider top: handshake FSM around prep, core and post stages.
// rst_n asserts asynchronously and is expected to deassert synchronously.
module intdiv_seq
  import intdiv_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int CW = $clog2(XLEN) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       size,
  input  logic             signed_mode,
  input  logic [XLEN-1:0]  dividend_hi,
  input  logic [XLEN-1:0]  dividend_lo,
  input  logic [XLEN-1:0]  divisor,
  output logic             busy,
  output logic             done,
  output logic [XLEN-1:0]  quotient,
  output logic [XLEN-1:0]  remainder,
  output logic             div_err
);

  div_state_e      st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  op_size_e        size_q;
  logic            sgn_q, negq_q, negr_q, early_q;
  logic [XLEN-1:0] quo_q, rem_q;
  logic            err_q, done_q, done_d;
  logic            accept, capture, publish;

  logic [XLEN-1:0] hi_mag, lo_al, dvs_mag;
  logic [CW-1:0]   nbits;
  logic            neg_q, neg_r, early;
  logic [XLEN-1:0] core_rem, core_quo, post_quo, post_rem;
  logic            post_err;

  intdiv_prep #(.XLEN(XLEN)) u_prep (
    .size_i      (op_size_e'(size)),
    .signed_i    (signed_mode),
    .hi_i        (dividend_hi),
    .lo_i        (dividend_lo),
    .dvs_i       (divisor),
    .hi_mag_o    (hi_mag),
    .lo_al_o     (lo_al),
    .dvs_mag_o   (dvs_mag),
    .nbits_o     (nbits),
    .neg_q_o     (neg_q),
    .neg_r_o     (neg_r),
    .early_err_o (early)
  );

  intdiv_core #(.XLEN(XLEN)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (accept),
    .step_i    (st_q == ST_RUN),
    .hi_mag_i  (hi_mag),
    .lo_al_i   (lo_al),
    .dvs_mag_i (dvs_mag),
    .rem_o     (core_rem),
    .quo_o     (core_quo)
  );

  intdiv_post #(.XLEN(XLEN)) u_post (
    .size_i   (size_q),
    .signed_i (sgn_q),
    .neg_q_i  (negq_q),
    .neg_r_i  (negr_q),
    .early_i  (early_q),
    .quo_i    (core_quo),
    .rem_i    (core_rem),
    .quo_o    (post_quo),
    .rem_o    (post_rem),
    .err_o    (post_err)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    accept  = 1'b0;
    capture = 1'b0;
    publish = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          accept  = 1'b1;
          capture = 1'b1;
          cnt_d   = nbits;
          st_d    = early ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CW'(1)) st_d = ST_FIN;
      end
      ST_FIN: begin
        publish = 1'b1;
        done_d  = 1'b1;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  // per-operation attributes, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q  <= SZ_B;
      sgn_q   <= 1'b0;
      negq_q  <= 1'b0;
      negr_q  <= 1'b0;
      early_q <= 1'b0;
    end else if (capture) begin
      size_q  <= op_size_e'(size);
      sgn_q   <= signed_mode;
      negq_q  <= signed_mode & neg_q;
      negr_q  <= signed_mode & neg_r;
      early_q <= early;
    end
  end

  // result registers, enabled on completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      err_q <= 1'b0;
    end else if (publish) begin
      quo_q <= post_quo;
      rem_q <= post_rem;
      err_q <= post_err;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign quotient  = quo_q;
  assign remainder = rem_q;
  assign div_err   = err_q;

  AST_ZERO_DIVISOR_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (dvs_mag == '0)) |=> (st_q == ST_FIN)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !signed_mode && (hi_mag >= dvs_mag)) |=> (st_q == ST_FIN)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (size_q == $past(size_q))); // R8
  AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_err))); // R9

endmodule

// File: tb/sim_intdiv_seq.sv
module sim_intdiv_seq;

  localparam int XLEN = 64;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [1:0]       size = 2'd0;
  logic             signed_mode = 1'b0;
  logic [XLEN-1:0]  dividend_hi = '0;
  logic [XLEN-1:0]  dividend_lo = '0;
  logic [XLEN-1:0]  divisor = '0;
  logic             busy, done, div_err;
  logic [XLEN-1:0]  quotient, remainder;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk; // 50 MHz

  intdiv_seq #(.XLEN(XLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .size(size),
    .signed_mode(signed_mode), .dividend_hi(dividend_hi),
    .dividend_lo(dividend_lo), .divisor(divisor), .busy(busy),
    .done(done), .quotient(quotient), .remainder(remainder),
    .div_err(div_err)
  );

  // behavioural reference: exact arithmetic on wide integers
  function automatic void ref_div(input int sz, input bit sg,
      input logic [63:0] h0, input logic [63:0] l0, input logic [63:0] d0,
      output logic [63:0] q, output logic [63:0] r, output bit e,
      output int lat, output string tag);
    int n;
    logic [129:0] one, m, h, l, d, dvd, ad, av, qq, rr, half;
    bit sd, sv, neg;
    n = 8 << sz;
    one = 130'd1;
    m = (one << n) - one;
    h = {66'd0, h0} & m;
    l = {66'd0, l0} & m;
    d = {66'd0, d0} & m;
    dvd = (h << n) | l;
    q = '0; r = '0; e = 1'b0; lat = n + 1; tag = "R1";
    if (!sg) begin
      if (d == 0) begin e = 1; lat = 1; tag = "R2"; end
      else if (h >= d) begin e = 1; lat = 1; tag = "R3"; end
      else begin qq = dvd / d; rr = dvd % d; q = qq[63:0]; r = rr[63:0]; end
    end else begin
      sd = dvd[2*n-1];
      sv = d[n-1];
      ad = sd ? ((one << (2*n)) - dvd) : dvd;
      av = sv ? ((one << n) - d) : d;
      neg = sd ^ sv;
      half = one << (n - 1);
      if (d == 0) begin e = 1; lat = 1; tag = "R2"; end
      else if ((ad >> n) >= av) begin e = 1; lat = 1; tag = "R5"; end
      else begin
        qq = ad / av; rr = ad % av;
        if (neg ? (qq > half) : (qq >= half)) begin e = 1; tag = "R5"; end
        else begin
          qq = neg ? (((one << n) - qq) & m) : qq;
          rr = sd ? (((one << n) - rr) & m) : rr;
          q = qq[63:0]; r = rr[63:0]; tag = "R4";
        end
      end
    end
  endfunction

  // cycle model
  int           m_cnt;
  bit           m_done, m_e, p_e;
  logic [63:0]  m_q, m_r, p_q, p_r;
  string        m_tag, p_tag;
  int           p_lat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_done <= 0; m_q <= '0; m_r <= '0; m_e <= 0; m_tag <= "R10";
    end else begin
      m_done <= 0;
      if (m_cnt == 0) begin
        if (start) begin
          ref_div(int'(size), signed_mode, dividend_hi, dividend_lo, divisor,
                  p_q, p_r, p_e, p_lat, p_tag);
          m_cnt <= p_lat;
        end
      end else begin
        m_cnt <= m_cnt - 1;
        if (m_cnt == 1) begin
          m_done <= 1; m_q <= p_q; m_r <= p_r; m_e <= p_e; m_tag <= p_tag;
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (cyc >= 2) begin
      n_chk++;
      if (busy !== (m_cnt != 0)) begin
        n_fail++;
        $display("FAIL R7 busy: actual %b expected %b", busy, (m_cnt != 0));
      end else if (done !== m_done) begin
        n_fail++;
        $display("FAIL R6 done: actual %b expected %b", done, m_done);
      end else if ({quotient, remainder, div_err} !== {m_q, m_r, m_e}) begin
        n_fail++;
        $display("FAIL %s: q=%h r=%h e=%b expected q=%h r=%h e=%b",
                 !rst_n ? "R10" : (m_done ? m_tag : "R9"),
                 quotient, remainder, div_err, m_q, m_r, m_e);
      end
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(input int sz, input bit sg,
                    input logic [63:0] h, input logic [63:0] l, input logic [63:0] d);
    size = 2'(sz); signed_mode = sg;
    dividend_hi = h; dividend_lo = l; divisor = d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_cnt != 0) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && quotient === '0, "R10", quotient, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 unsigned, each width; junk upper bits must not matter
    op(0, 0, 64'h12, 64'h34, 64'h56);
    check(quotient === 64'd54 && remainder === 64'd16, "R1", quotient, 64'd54);
    op(0, 0, 64'hABCD12, 64'hFFFF34, 64'h777756);
    check(quotient === 64'd54 && remainder === 64'd16, "R1", quotient, 64'd54);
    op(1, 0, 64'h1, 64'h0, 64'h2);
    op(2, 0, 64'h1234, 64'h89AB_CDEF, 64'h0001_0003);
    op(3, 0, 64'h1, 64'h0, 64'h2);
    check(quotient === 64'h8000_0000_0000_0000, "R1", quotient, 64'h8000_0000_0000_0000);
    // R2 zero divisor, R3 unsigned overflow
    op(0, 0, 64'h5, 64'h0, 64'h100);
    check(div_err === 1'b1, "R2", {63'd0, div_err}, 64'd1);
    op(3, 1, 64'h0, 64'h7, 64'h0);
    op(3, 0, 64'h5, 64'h1, 64'h5);
    check(div_err === 1'b1 && quotient === '0, "R3", {63'd0, div_err}, 64'd1);
    // R4 signed truncation and remainder sign
    op(0, 1, 64'hFF, 64'hF9, 64'h02);
    check(quotient === 64'hFD && remainder === 64'hFF, "R4", quotient, 64'hFD);
    op(2, 1, 64'h0, 64'd100, 64'hFFFF_FFF9);
    // R5 signed bounds
    op(0, 1, 64'hFF, 64'h00, 64'h02);
    check(quotient === 64'h80 && div_err === 1'b0, "R5", quotient, 64'h80);
    op(0, 1, 64'hFF, 64'h80, 64'hFF);
    check(div_err === 1'b1, "R5", {63'd0, div_err}, 64'd1);
    op(0, 1, 64'h00, 64'h80, 64'hFF);
    op(3, 1, '1, 64'h8000_0000_0000_0000, '1);
    op(3, 1, 64'h0, 64'h8000_0000_0000_0000, '1);
    op(1, 1, 64'h7FFF, 64'hFFFF, 64'h7FFF);

    // R8: start while busy is ignored; R6 timing of the first op kept
    begin
      int lat_seen;
      size = 2'd0; signed_mode = 1'b0;
      dividend_hi = 64'h12; dividend_lo = 64'h34; divisor = 64'h56;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat_seen = 1;
      @(negedge clk);
      size = 2'd3; dividend_hi = '0; dividend_lo = 64'h10; divisor = 64'h1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat_seen = 3;
      while (!done) begin @(negedge clk); lat_seen++; end
      check(quotient === 64'd54 && remainder === 64'd16, "R8", quotient, 64'd54);
      check(lat_seen == 10, "R6", 64'(lat_seen), 64'd10);
      @(negedge clk);
      check(done === 1'b0 && busy === 1'b0, "R7", {63'd0, done}, 64'd0);
    end

    // mixed sweep
    for (int i = 0; i < 240; i++) begin
      int sz;
      bit sg;
      logic [63:0] h, l, d, mk;
      sz = int'($urandom % 4);
      sg = 1'($urandom);
      mk = (sz == 3) ? '1 : ((64'd1 << (8 << sz)) - 64'd1);
      l = {$urandom, $urandom};
      d = {$urandom, $urandom};
      h = {$urandom, $urandom};
      if (i % 16 == 5) d = '0;
      else if (i % 8 != 3) begin
        if (sg) h = (1'($urandom)) ? mk : '0;
        else if ((d & mk) != 0) h = (h & mk) % (d & mk);
      end
      op(sz, sg, h, l, d);
    end

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule